// File: doc/BRIEF.md
# USB OUT endpoint receive controller

This block decides how one USB device endpoint responds to host-to-device traffic. The serial interface engine reports decoded tokens and the outcome of each data packet. The block keeps an 8-bit control/status word that software reads and writes. From that word it decides whether the endpoint answers the packet, which handshake it returns, and whether the payload goes into the buffer.

A token arms the endpoint only when the token's endpoint number equals the programmed address. A SETUP token also needs the endpoint to be marked as a control endpoint. The data packet that follows is judged against the receive status and the expected data toggle. A good packet with the expected toggle is acknowledged and accepted. The block then parks the endpoint in NAK and raises a sticky transfer-complete flag, so that software has time to empty the buffer before it re-enables reception.

Top module: `usb_out_ep_rx`

## Requirements
- R1: `sw_rdata` presents the register as {ctrl[7], dtog[6], stat[5:4], ea[3:0]}. A `sw_wr` pulse loads all four fields from `sw_wdata` at the same bit positions.
- R2: `rst_n` low clears the register and `ctr`. A `bus_rst` pulse clears bits [7:4] and `ctr`, keeps `ea`, and discards any armed token.
- R3: Only a token whose `tok_ep` equals `ea` arms the endpoint. A packet that follows a non-matching token, or that has no token before it, produces no handshake and no change.
- R4: Status encoding: 00 = disabled, 01 = stall, 10 = NAK, 11 = valid. An armed, error-free packet gets no handshake when disabled, STALL when stalled, and NAK when NAKing, with no state change. Handshake codes are 00 = ACK, 01 = NAK, 10 = STALL.
- R5: In the valid state, an error-free packet whose PID bit (`pkt_pid1`, 1 = DATA1) equals `dtog` is answered with ACK and `data_accept`, and `dtog` inverts.
- R6: An accepted packet sets `stat` to NAK (10) and sets `ctr`.
- R7: In the valid state, an error-free packet whose PID bit differs from `dtog` gets ACK without `data_accept`. `dtog`, `stat` and `ctr` stay unchanged.
- R8: A packet with `pkt_err` high gets no handshake and leaves the register and `ctr` unchanged.
- R9: A matching SETUP token clears `dtog` only when `ctrl` = 1. With `ctrl` = 0 a SETUP token is ignored, and the packet after it gets no handshake.
- R10: `ctr` stays set until a `ctr_clr` pulse. A hardware set in the same cycle as `ctr_clr` wins.
- R11: When `sw_wr` coincides with an accepted packet, the hardware values of `stat` (NAK) and `dtog` (toggled) win. `ctrl` and `ea` take the written value.
- R12: `hs_valid`, `hs_code` and `data_accept` are one-cycle pulses in the cycle after `pkt_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | USB bus reset pulse (synchronous) |
| sw_wr | input | 1 | Software register write strobe |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Register read value |
| ctr_clr | input | 1 | Clears the transfer-complete flag |
| tok_valid | input | 1 | Token decoded (one-cycle pulse) |
| tok_setup | input | 1 | 1 = SETUP token, 0 = OUT token |
| tok_ep | input | 4 | Endpoint field of the token |
| pkt_valid | input | 1 | Data packet finished (one-cycle pulse) |
| pkt_pid1 | input | 1 | Packet PID was DATA1 |
| pkt_err | input | 1 | CRC or bit-stuff error in the packet |
| hs_valid | output | 1 | Send a handshake |
| hs_code | output | 2 | Handshake kind: 00 ACK, 01 NAK, 10 STALL |
| data_accept | output | 1 | Commit packet payload to buffer |
| ctr | output | 1 | Sticky transfer-complete flag |

## Verification
The hardest case to reach is a software write that lands in the same cycle as the hardware's forced NAK and toggle update. The bench drives `sw_wr` on the same clock as `pkt_valid` after arming with a matching token, then reads back that the status and toggle came from hardware. The bench also exercises a SETUP token on a control endpoint whose toggle was preset to DATA1, and confirms the toggle reads back as DATA0 before the data packet arrives. A second SETUP token is sent to a non-control endpoint, and the bench checks that the toggle stays put.

// File: rtl/usb_ep_rx_pkg.sv
package usb_ep_rx_pkg;
    localparam int EP_W = 4;

    typedef enum logic [1:0] {
        ST_OFF   = 2'b00,
        ST_STALL = 2'b01,
        ST_NAK   = 2'b10,
        ST_VALID = 2'b11
    } rx_stat_e;

    typedef enum logic [1:0] {
        HS_ACK   = 2'b00,
        HS_NAK   = 2'b01,
        HS_STALL = 2'b10
    } hs_kind_e;

    typedef struct packed {
        logic            ctrl;
        logic            dtog;
        rx_stat_e        stat;
        logic [EP_W-1:0] ea;
    } ep_reg_t;
endpackage

// File: rtl/usb_ep_tok_match.sv
module usb_ep_tok_match #(
    parameter int EP_W = 4
) (
    input  logic            tok_valid,
    input  logic            tok_setup,
    input  logic [EP_W-1:0] tok_ep,
    input  logic [EP_W-1:0] ea,
    input  logic            ctrl,
    output logic            arm,
    output logic            setup_hit
);
    logic addr_eq;

    always_comb begin
        addr_eq   = (tok_ep == ea);
        arm       = tok_valid && addr_eq && (!tok_setup || ctrl);
        setup_hit = tok_valid && addr_eq && tok_setup && ctrl;
    end
endmodule

// File: rtl/usb_ep_rx_decide.sv
module usb_ep_rx_decide
    import usb_ep_rx_pkg::*;
(
    input  logic     armed,
    input  logic     pkt_valid,
    input  logic     pkt_pid1,
    input  logic     pkt_err,
    input  rx_stat_e stat,
    input  logic     dtog,
    output logic     hs_en,
    output hs_kind_e hs_kind,
    output logic     accept
);
    logic judge;

    always_comb begin
        judge   = armed && pkt_valid && !pkt_err;
        hs_en   = 1'b0;
        hs_kind = HS_ACK;
        accept  = 1'b0;
        if (judge) begin
            unique case (stat)
                ST_OFF:   hs_en = 1'b0;
                ST_STALL: begin hs_en = 1'b1; hs_kind = HS_STALL; end
                ST_NAK:   begin hs_en = 1'b1; hs_kind = HS_NAK;   end
                ST_VALID: begin
                    hs_en   = 1'b1;
                    hs_kind = HS_ACK;
                    accept  = (pkt_pid1 == dtog);
                end
                default:  hs_en = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/usb_out_ep_rx.sv
module usb_out_ep_rx
    import usb_ep_rx_pkg::*;
#(
    parameter int EPW = 4,
    localparam int REG_W = EPW + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rst,
    input  logic             sw_wr,
    input  logic [REG_W-1:0] sw_wdata,
    output logic [REG_W-1:0] sw_rdata,
    input  logic             ctr_clr,
    input  logic             tok_valid,
    input  logic             tok_setup,
    input  logic [EPW-1:0]   tok_ep,
    input  logic             pkt_valid,
    input  logic             pkt_pid1,
    input  logic             pkt_err,
    output logic             hs_valid,
    output logic [1:0]       hs_code,
    output logic             data_accept,
    output logic             ctr
);
    typedef struct packed {
        logic           ctrl;
        logic           dtog;
        rx_stat_e       stat;
        logic [EPW-1:0] ea;
        logic           ctr;
        logic           armed;
        logic           hs_v;
        hs_kind_e       hs_k;
        logic           acc;
    } state_t;

    state_t st_d, st_q;

    logic     arm_w, setup_w;
    logic     hs_en_w, accept_w;
    hs_kind_e hs_kind_w;

    usb_ep_tok_match #(.EP_W(EPW)) match_i (
        .tok_valid (tok_valid),
        .tok_setup (tok_setup),
        .tok_ep    (tok_ep),
        .ea        (st_q.ea),
        .ctrl      (st_q.ctrl),
        .arm       (arm_w),
        .setup_hit (setup_w)
    );

    usb_ep_rx_decide decide_i (
        .armed     (st_q.armed),
        .pkt_valid (pkt_valid),
        .pkt_pid1  (pkt_pid1),
        .pkt_err   (pkt_err),
        .stat      (st_q.stat),
        .dtog      (st_q.dtog),
        .hs_en     (hs_en_w),
        .hs_kind   (hs_kind_w),
        .accept    (accept_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.hs_v = 1'b0;
        st_d.hs_k = HS_ACK;
        st_d.acc  = 1'b0;

        // software write first; hardware updates below override it
        if (sw_wr) begin
            st_d.ctrl = sw_wdata[REG_W-1];
            st_d.dtog = sw_wdata[REG_W-2];
            st_d.stat = rx_stat_e'(sw_wdata[REG_W-3 -: 2]);
            st_d.ea   = sw_wdata[EPW-1:0];
        end
        if (ctr_clr) st_d.ctr = 1'b0;

        if (pkt_valid) st_d.armed = 1'b0;
        if (tok_valid) st_d.armed = arm_w;
        if (setup_w)   st_d.dtog  = 1'b0;

        if (hs_en_w) begin
            st_d.hs_v = 1'b1;
            st_d.hs_k = hs_kind_w;
        end
        if (accept_w) begin
            st_d.acc  = 1'b1;
            st_d.dtog = ~st_q.dtog;
            st_d.stat = ST_NAK;
            st_d.ctr  = 1'b1;
        end

        if (bus_rst) begin
            st_d.ctrl  = 1'b0;
            st_d.dtog  = 1'b0;
            st_d.stat  = ST_OFF;
            st_d.ctr   = 1'b0;
            st_d.armed = 1'b0;
            st_d.hs_v  = 1'b0;
            st_d.acc   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sw_rdata    = {st_q.ctrl, st_q.dtog, st_q.stat, st_q.ea};
    assign hs_valid    = st_q.hs_v;
    assign hs_code     = st_q.hs_k;
    assign data_accept = st_q.acc;
    assign ctr         = st_q.ctr;

    // R6
    accept_forces_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_accept |-> (sw_rdata[REG_W-3 -: 2] == 2'b10) && ctr);

    // R5
    accept_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_accept |-> hs_valid && (hs_code == 2'b00));

    // R12
    hs_follows_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> $past(pkt_valid));

    // R5
    dtog_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sw_rdata[REG_W-2]) |->
            (data_accept || $past(sw_wr) || $past(bus_rst) || $past(tok_valid)));

    // R10
    ctr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctr) |-> $past(ctr_clr) || $past(bus_rst));
endmodule

// File: tb/usb_out_ep_rx_tb.sv
module usb_out_ep_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rst = 1'b0;
    logic       sw_wr = 1'b0;
    logic [7:0] sw_wdata = '0;
    logic [7:0] sw_rdata;
    logic       ctr_clr = 1'b0;
    logic       tok_valid = 1'b0;
    logic       tok_setup = 1'b0;
    logic [3:0] tok_ep = '0;
    logic       pkt_valid = 1'b0;
    logic       pkt_pid1 = 1'b0;
    logic       pkt_err = 1'b0;
    logic       hs_valid;
    logic [1:0] hs_code;
    logic       data_accept;
    logic       ctr;

    int n_run = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    usb_out_ep_rx dut_i (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
        .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .ctr_clr(ctr_clr),
        .tok_valid(tok_valid), .tok_setup(tok_setup), .tok_ep(tok_ep),
        .pkt_valid(pkt_valid), .pkt_pid1(pkt_pid1), .pkt_err(pkt_err),
        .hs_valid(hs_valid), .hs_code(hs_code),
        .data_accept(data_accept), .ctr(ctr)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] v);
        @(negedge clk); sw_wr = 1'b1; sw_wdata = v;
        @(negedge clk); sw_wr = 1'b0;
    endtask

    task automatic token(bit setup, logic [3:0] ep);
        @(negedge clk); tok_valid = 1'b1; tok_setup = setup; tok_ep = ep;
        @(negedge clk); tok_valid = 1'b0; tok_setup = 1'b0;
    endtask

    // drives a packet; checks handshake pulse one cycle later ({hs_valid,hs_code,accept})
    task automatic packet(string req, bit pid1, bit err, logic [3:0] exp_hs);
        @(negedge clk); pkt_valid = 1'b1; pkt_pid1 = pid1; pkt_err = err;
        @(negedge clk); pkt_valid = 1'b0; pkt_err = 1'b0;
        check(req, {4'h0, hs_valid, hs_code, data_accept}, {4'h0, exp_hs});
        @(negedge clk);
        check({req, " pulse"}, {5'h0, hs_valid, data_accept}, 8'h0);
    endtask

    task automatic t_reset();
        check("R2 reset reg", sw_rdata, 8'h00);
        check("R2 reset out", {5'h0, hs_valid, data_accept, ctr}, 8'h0);
    endtask

    task automatic t_status_modes();
        wr(8'h01);                         // disabled, ep1
        token(1'b0, 4'd1);
        packet("R4 disabled", 1'b0, 1'b0, 4'b0000);
        wr(8'h11);                         // stall
        token(1'b0, 4'd1);
        packet("R4 stall", 1'b0, 1'b0, 4'b1100);
        check("R4 stall reg", sw_rdata, 8'h11);
        wr(8'h21);                         // nak
        token(1'b0, 4'd1);
        packet("R4 nak", 1'b0, 1'b0, 4'b1010);
        check("R4 nak ctr", {7'h0, ctr}, 8'h0);
    endtask

    task automatic t_good_rx();
        wr(8'h31);
        token(1'b0, 4'd1);
        packet("R5 accept", 1'b0, 1'b0, 4'b1001);
        check("R6 reg after accept", sw_rdata, 8'h61);
        check("R6 ctr", {7'h0, ctr}, 8'h1);
        check("R1 read layout", sw_rdata[3:0], 4'h1);
    endtask

    task automatic t_mismatch_err_addr();
        wr(8'h71);                         // valid, expect DATA1
        token(1'b0, 4'd1);
        packet("R7 pid mismatch", 1'b0, 1'b0, 4'b1000);
        check("R7 reg kept", sw_rdata, 8'h71);
        token(1'b0, 4'd2);
        packet("R3 addr mismatch", 1'b1, 1'b0, 4'b0000);
        packet("R3 no token", 1'b1, 1'b0, 4'b0000);
        token(1'b0, 4'd1);
        packet("R8 crc error", 1'b1, 1'b1, 4'b0000);
        check("R8 reg kept", sw_rdata, 8'h71);
    endtask

    task automatic t_setup();
        token(1'b1, 4'd1);                 // ctrl=0: ignored
        check("R9 non-ctrl setup dtog", sw_rdata, 8'h71);
        packet("R9 non-ctrl setup", 1'b0, 1'b0, 4'b0000);
        wr(8'hF1);
        token(1'b1, 4'd1);
        check("R9 setup clears dtog", sw_rdata, 8'hB1);
        packet("R9 setup data", 1'b0, 1'b0, 4'b1001);
        check("R9 reg after setup", sw_rdata, 8'hE1);
    endtask

    task automatic t_ctr_clear();
        check("R10 sticky", {7'h0, ctr}, 8'h1);
        @(negedge clk); ctr_clr = 1'b1;
        @(negedge clk); ctr_clr = 1'b0;
        check("R10 cleared", {7'h0, ctr}, 8'h0);
    endtask

    task automatic t_collision();
        wr(8'h31);
        token(1'b0, 4'd1);
        @(negedge clk);
        pkt_valid = 1'b1; pkt_pid1 = 1'b0; sw_wr = 1'b1; sw_wdata = 8'hB2;
        @(negedge clk);
        pkt_valid = 1'b0; sw_wr = 1'b0;
        check("R11 accept during write", {7'h0, data_accept}, 8'h1);
        check("R11 hw wins", sw_rdata, 8'hE2);
        // ctr_clr together with a hardware set: set wins
        wr(8'h32);
        token(1'b0, 4'd2);
        @(negedge clk); pkt_valid = 1'b1; ctr_clr = 1'b1; pkt_pid1 = 1'b0;
        @(negedge clk); pkt_valid = 1'b0; ctr_clr = 1'b0;
        check("R10 set beats clear", {7'h0, ctr}, 8'h1);
    endtask

    task automatic t_bus_reset();
        wr(8'hF5);
        token(1'b0, 4'd5);
        @(negedge clk); bus_rst = 1'b1;
        @(negedge clk); bus_rst = 1'b0;
        check("R2 bus reset reg", sw_rdata, 8'h05);
        check("R2 bus reset ctr", {7'h0, ctr}, 8'h0);
        packet("R2 armed dropped", 1'b0, 1'b0, 4'b0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_status_modes();
        t_good_rx();
        t_mismatch_err_addr();
        t_setup();
        t_ctr_clear();
        t_collision();
        t_bus_reset();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end
endmodule